// File: doc/BRIEF.md
# Interrupt Tail-Chaining Jump Unit

This unit carries out the execute stage of a special control-register instruction. The instruction chains straight into the next waiting interrupt handler, so software does not need a full return followed by a fresh trap entry. When the execute strobe is high, the unit reads the interrupt arbiter's current winner and checks whether that winner is eligible. It always turns the global interrupt enable back on. When the winner is eligible, the unit issues a jump-and-link to the winner's handler. The link value is the address of the instruction itself. When the handler returns, it therefore runs the same instruction again, which looks once more for queued work.

The handler entry is a word in a vector table. The unit computes the word's address from the table base and the winner's source number and presents it combinationally on a lookup port. The read data is expected back in the same cycle. When the chosen winner is edge-triggered, the unit sends the arbiter a one-cycle acknowledge carrying the source number, so the arbiter can clear that pending bit. When no winner is eligible, the instruction falls through. There is no jump, no link write and no acknowledge. The only effect is that interrupts are enabled again.

All results are registered. They appear in the cycle after the execute strobe and each lasts exactly one cycle.

Top module: `tcj_unit`

## Requirements
- R1: While reset is asserted and immediately after it, `redirect_o`, `link_we_o`, `ack_o` and `gie_o` are 0.
- R2: An execute strobe sets `gie_o` to 1 from the next cycle. A `trap_clr_i` pulse without an execute strobe clears it from the next cycle. When both are high in the same cycle, the enable ends up set.
- R3: A winner is eligible only when `win_valid_i`, `win_enabled_i` and `win_vectored_i` are all 1 and `win_level_i` is strictly greater than `threshold_i`. A level equal to the threshold is not eligible.
- R4: For an eligible winner, `redirect_o` is 1 in the cycle after the strobe. `target_pc_o` then equals the `tbl_data_i` value that was present during the strobe cycle.
- R5: Whenever a jump is taken, `link_we_o` is 1 in the same cycle as `redirect_o`, and `link_data_o` equals the `instr_pc_i` of the strobe cycle, not that value plus 4.
- R6: When the winner is not eligible, the cycle after the strobe shows `redirect_o`, `link_we_o` and `ack_o` all at 0.
- R7: `ack_o` is 1 only for a taken jump whose winner had `win_edge_i`=1. In that cycle `ack_id_o` equals the winner's `win_id_i`.
- R8: `redirect_o`, `link_we_o` and `ack_o` stay high for one cycle only, and they stay 0 in any cycle that does not follow an execute strobe.
- R9: `tbl_addr_o` always equals `table_base_i + 4 * win_id_i`, computed combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe for the chaining instruction |
| instr_pc_i | input | XLEN | Address of the executing instruction |
| trap_clr_i | input | 1 | Trap entry: clears global interrupt enable |
| win_valid_i | input | 1 | Arbiter winner is pending |
| win_enabled_i | input | 1 | Winner's source is enabled |
| win_vectored_i | input | 1 | Winner may be taken on the vectored chaining path |
| win_edge_i | input | 1 | Winner is edge-triggered |
| win_id_i | input | ID_W | Winner's source number |
| win_level_i | input | LVL_W | Winner's level |
| threshold_i | input | LVL_W | Current level threshold |
| table_base_i | input | XLEN | Vector table base address |
| tbl_addr_o | output | XLEN | Lookup address of the winner's table entry |
| tbl_data_i | input | XLEN | Table entry read back in the same cycle |
| gie_o | output | 1 | Global interrupt enable |
| redirect_o | output | 1 | Take the jump |
| target_pc_o | output | XLEN | Handler address for the jump |
| link_we_o | output | 1 | Write the link register |
| link_data_o | output | XLEN | Link value (address of the instruction) |
| ack_o | output | 1 | Clear the pending bit of an edge source |
| ack_id_o | output | ID_W | Source number being acknowledged |

## Verification
The assertions assume that every input is at a defined value from reset onward. They also assume the table read data is stable for the whole strobe cycle, because the target check compares against the previous cycle's `tbl_data_i`. The bench drives every input to 0 during reset and changes inputs only on the falling edge. It feeds the table read data from a local array indexed by the unit's own lookup address, so the returned word depends only on the winner presented in that cycle. During chaining, the bench removes a source from its queue only after seeing an acknowledge for it. This matches how an arbiter would behave after the clear.

// File: rtl/tcj_pkg.sv
package tcj_pkg;
  // Outcome of one execution of the chaining instruction
  typedef enum logic [1:0] {
    TCJ_IDLE = 2'd0,
    TCJ_FALL = 2'd1,
    TCJ_TAKE = 2'd2
  } tcj_outcome_e;

  // Word size of a vector table entry in address units
  localparam int unsigned TCJ_ENTRY_BYTES = 4;
endpackage

// File: rtl/tcj_elig.sv
module tcj_elig #(
  parameter int unsigned LVL_W     = 8,
  parameter bit          STRICT_GT = 1'b1
) (
  input  logic             valid_i,
  input  logic             enabled_i,
  input  logic             vectored_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] thresh_i,
  output logic             eligible_o
);
  logic above;

  generate
    if (STRICT_GT) begin : g_strict
      assign above = (level_i > thresh_i);
    end else begin : g_incl
      assign above = (level_i >= thresh_i);
    end
  endgenerate

  assign eligible_o = valid_i & enabled_i & vectored_i & above;
endmodule

// File: rtl/tcj_addr.sv
module tcj_addr #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned ID_W = 4
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [ID_W-1:0] id_i,
  output logic [XLEN-1:0] addr_o
);
  import tcj_pkg::*;
  localparam int unsigned SHIFT = $clog2(TCJ_ENTRY_BYTES);

  logic [XLEN-1:0] offset;

  always_comb begin
    offset = '0;
    offset[ID_W-1:0] = id_i;
    offset = offset << SHIFT;
  end

  assign addr_o = base_i + offset;
endmodule

// File: rtl/tcj_gie.sv
module tcj_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic gie_o
);
  logic gie_q, gie_d;

  always_comb begin
    gie_d = gie_q;
    if (clr_i) gie_d = 1'b0;
    if (set_i) gie_d = 1'b1;   // set has priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/tcj_unit.sv
module tcj_unit #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned LVL_W   = 8,
  localparam int unsigned ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exec_i,
  input  logic [XLEN-1:0]  instr_pc_i,
  input  logic             trap_clr_i,
  input  logic             win_valid_i,
  input  logic             win_enabled_i,
  input  logic             win_vectored_i,
  input  logic             win_edge_i,
  input  logic [ID_W-1:0]  win_id_i,
  input  logic [LVL_W-1:0] win_level_i,
  input  logic [LVL_W-1:0] threshold_i,
  input  logic [XLEN-1:0]  table_base_i,
  output logic [XLEN-1:0]  tbl_addr_o,
  input  logic [XLEN-1:0]  tbl_data_i,
  output logic             gie_o,
  output logic             redirect_o,
  output logic [XLEN-1:0]  target_pc_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic             ack_o,
  output logic [ID_W-1:0]  ack_id_o
);
  import tcj_pkg::*;

  logic eligible;

  tcj_elig #(.LVL_W(LVL_W), .STRICT_GT(1'b1)) i_elig (
    .valid_i    (win_valid_i),
    .enabled_i  (win_enabled_i),
    .vectored_i (win_vectored_i),
    .level_i    (win_level_i),
    .thresh_i   (threshold_i),
    .eligible_o (eligible)
  );

  tcj_addr #(.XLEN(XLEN), .ID_W(ID_W)) i_addr (
    .base_i (table_base_i),
    .id_i   (win_id_i),
    .addr_o (tbl_addr_o)
  );

  tcj_gie i_gie (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (exec_i),
    .clr_i (trap_clr_i),
    .gie_o (gie_o)
  );

  // Next-state
  tcj_outcome_e outc_d, outc_q;
  logic         ack_d, ack_q;
  logic         load_en;
  logic [XLEN-1:0] target_d, target_q, link_d, link_q;
  logic [ID_W-1:0] ack_id_d, ack_id_q;

  always_comb begin
    outc_d = TCJ_IDLE;
    if (exec_i) outc_d = eligible ? TCJ_TAKE : TCJ_FALL;
    ack_d    = (outc_d == TCJ_TAKE) & win_edge_i;
    load_en  = (outc_d == TCJ_TAKE);
    target_d = load_en ? tbl_data_i : target_q;
    link_d   = load_en ? instr_pc_i : link_q;
    ack_id_d = ack_d ? win_id_i : ack_id_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outc_q   <= TCJ_IDLE;
      ack_q    <= 1'b0;
      target_q <= '0;
      link_q   <= '0;
      ack_id_q <= '0;
    end else begin
      outc_q   <= outc_d;
      ack_q    <= ack_d;
      target_q <= target_d;
      link_q   <= link_d;
      ack_id_q <= ack_id_d;
    end
  end

  assign redirect_o  = (outc_q == TCJ_TAKE);
  assign link_we_o   = (outc_q == TCJ_TAKE);
  assign target_pc_o = target_q;
  assign link_data_o = link_q;
  assign ack_o       = ack_q;
  assign ack_id_o    = ack_id_q;
endmodule

// File: rtl/tcj_unit_chk.sv
module tcj_unit_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned ID_W  = 4,
  parameter int unsigned LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exec_i,
  input logic [XLEN-1:0]  instr_pc_i,
  input logic             win_valid_i,
  input logic             win_enabled_i,
  input logic             win_vectored_i,
  input logic             win_edge_i,
  input logic [ID_W-1:0]  win_id_i,
  input logic [LVL_W-1:0] win_level_i,
  input logic [LVL_W-1:0] threshold_i,
  input logic [XLEN-1:0]  tbl_data_i,
  input logic             gie_o,
  input logic             redirect_o,
  input logic [XLEN-1:0]  target_pc_o,
  input logic             link_we_o,
  input logic [XLEN-1:0]  link_data_o,
  input logic             ack_o,
  input logic [ID_W-1:0]  ack_id_o
);
  // R2
  exec_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> gie_o);
  // R8
  redirect_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $past(exec_i));
  // R3
  redirect_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> ($past(win_valid_i) && $past(win_enabled_i) && $past(win_vectored_i)
                    && ($past(win_level_i) > $past(threshold_i))));
  // R4
  target_from_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (target_pc_o == $past(tbl_data_i)));
  // R5
  link_is_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (link_we_o && link_data_o == $past(instr_pc_i)));
  // R7
  ack_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (redirect_o && $past(win_edge_i) && ack_id_o == $past(win_id_i)));
  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o || $past(exec_i));
endmodule

bind tcj_unit tcj_unit_chk #(.XLEN(XLEN), .ID_W(ID_W), .LVL_W(LVL_W)) i_tcj_unit_chk (
  .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_pc_i(instr_pc_i),
  .win_valid_i(win_valid_i), .win_enabled_i(win_enabled_i),
  .win_vectored_i(win_vectored_i), .win_edge_i(win_edge_i), .win_id_i(win_id_i),
  .win_level_i(win_level_i), .threshold_i(threshold_i), .tbl_data_i(tbl_data_i),
  .gie_o(gie_o), .redirect_o(redirect_o), .target_pc_o(target_pc_o),
  .link_we_o(link_we_o), .link_data_o(link_data_o), .ack_o(ack_o), .ack_id_o(ack_id_o)
);

// File: tb/test_tcj_unit.sv
module test_tcj_unit;
  localparam int unsigned XLEN = 32;
  localparam int unsigned ID_W = 4;
  localparam int unsigned LVL_W = 8;

  logic clk, rst_n;
  logic exec, trap_clr, w_valid, w_en, w_vec, w_edge;
  logic [ID_W-1:0]  w_id;
  logic [LVL_W-1:0] w_lvl, thr;
  logic [XLEN-1:0]  pc, base, tbl_addr, tbl_data, target, link_data;
  logic gie, redirect, link_we, ack;
  logic [ID_W-1:0] ack_id;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [XLEN-1:0] vt [16];
  logic [XLEN-1:0] rel;
  assign rel = (tbl_addr - base) >> 2;
  assign tbl_data = vt[rel[3:0]];

  function automatic logic [XLEN-1:0] hnd(input logic [ID_W-1:0] id);
    return 32'h8000_0000 + 32'h40 * XLEN'(id);
  endfunction

  tcj_unit #(.XLEN(XLEN), .NUM_SRC(16), .LVL_W(LVL_W)) i_tcj_unit (
    .clk(clk), .rst_n(rst_n), .exec_i(exec), .instr_pc_i(pc), .trap_clr_i(trap_clr),
    .win_valid_i(w_valid), .win_enabled_i(w_en), .win_vectored_i(w_vec),
    .win_edge_i(w_edge), .win_id_i(w_id), .win_level_i(w_lvl), .threshold_i(thr),
    .table_base_i(base), .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data),
    .gie_o(gie), .redirect_o(redirect), .target_pc_o(target),
    .link_we_o(link_we), .link_data_o(link_data), .ack_o(ack), .ack_id_o(ack_id)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      summary();
    end
  end

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic v, en, vec, edg;
    logic [3:0] id;
    logic [7:0] lvl, thr;
    logic [31:0] pc;
    logic take, ak;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1,1'b1,1'b1,1'b0,4'd3, 8'd5,  8'd2,32'h0000_0100,1'b1,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,4'd4, 8'd9,  8'd8,32'h0000_0104,1'b1,1'b1},
    '{1'b1,1'b1,1'b1,1'b1,4'd6, 8'd7,  8'd7,32'h0000_0108,1'b0,1'b0},
    '{1'b1,1'b0,1'b1,1'b1,4'd6, 8'd9,  8'd1,32'h0000_010c,1'b0,1'b0},
    '{1'b1,1'b1,1'b0,1'b1,4'd6, 8'd9,  8'd1,32'h0000_0110,1'b0,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,4'd6, 8'd9,  8'd1,32'h0000_0114,1'b0,1'b0},
    '{1'b1,1'b1,1'b1,1'b1,4'd15,8'd255,8'd0,32'h0000_0118,1'b1,1'b1},
    '{1'b1,1'b1,1'b1,1'b0,4'd0, 8'd1,  8'd0,32'h0000_011c,1'b1,1'b0}
  };

  task automatic set_win(input vec_t t);
    w_valid = t.v; w_en = t.en; w_vec = t.vec; w_edge = t.edg;
    w_id = t.id; w_lvl = t.lvl; thr = t.thr; pc = t.pc;
  endtask

  // Strobe for one cycle; return at the negedge where registered outputs show.
  task automatic strobe();
    @(negedge clk); exec = 1'b1;
    @(negedge clk); exec = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) vt[i] = hnd(ID_W'(i));
    rst_n = 1'b0; exec = 0; trap_clr = 0; w_valid = 0; w_en = 0; w_vec = 0;
    w_edge = 0; w_id = '0; w_lvl = '0; thr = '0; pc = '0; base = 32'h0000_1000;
    repeat (3) @(negedge clk);
    check("R1 redirect in reset", {31'b0, redirect}, 0);
    check("R1 gie in reset", {31'b0, gie}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 link_we after reset", {31'b0, link_we}, 0);
    check("R1 ack after reset", {31'b0, ack}, 0);

    // Vector table walk (R3 R4 R5 R6 R7)
    for (int k = 0; k < 8; k++) begin
      set_win(VECS[k]);
      strobe();
      check("R4/R6 redirect", {31'b0, redirect}, {31'b0, VECS[k].take});
      check("R5/R6 link_we", {31'b0, link_we}, {31'b0, VECS[k].take});
      check("R7 ack", {31'b0, ack}, {31'b0, VECS[k].ak});
      if (VECS[k].take) begin
        check("R4 target", target, hnd(VECS[k].id));
        check("R5 link data", link_data, VECS[k].pc);
      end
      if (VECS[k].ak) check("R7 ack id", {28'b0, ack_id}, {28'b0, VECS[k].id});
      check("R2 gie after exec", {31'b0, gie}, 1);
      @(negedge clk);
      check("R8 redirect one cycle", {31'b0, redirect}, 0);
      check("R8 ack one cycle", {31'b0, ack}, 0);
    end

    // R9 table address combinational
    base = 32'h0000_2000; w_id = 4'd7; #1;
    check("R9 tbl addr", tbl_addr, 32'h0000_201c);
    base = 32'h0000_1000; #1;
    check("R9 tbl addr base change", tbl_addr, 32'h0000_101c);

    // R2 clear alone, then clear with exec
    @(negedge clk); trap_clr = 1'b1;
    @(negedge clk); trap_clr = 1'b0;
    check("R2 clear", {31'b0, gie}, 0);
    w_valid = 0;
    @(negedge clk); trap_clr = 1'b1; exec = 1'b1;
    @(negedge clk); trap_clr = 1'b0; exec = 1'b0;
    check("R2 set wins", {31'b0, gie}, 1);

    // R8 eligible winner present without strobe
    w_valid = 1; w_en = 1; w_vec = 1; w_edge = 1; w_lvl = 8'd50; thr = 8'd1;
    repeat (2) @(negedge clk);
    check("R8 no redirect without exec", {31'b0, redirect}, 0);
    check("R8 no ack without exec", {31'b0, ack}, 0);

    // Chaining through three queued edge interrupts, then fall through
    begin
      logic [3:0] q [3];
      int head;
      logic [XLEN-1:0] last_link;
      q[0] = 4'd5; q[1] = 4'd9; q[2] = 4'd2; head = 0;
      pc = 32'h0000_0200;
      while (head < 3) begin
        @(negedge clk); trap_clr = 1'b1;
        @(negedge clk); trap_clr = 1'b0;
        check("R2 trap entry clears", {31'b0, gie}, 0);
        w_valid = 1; w_id = q[head]; w_lvl = 8'd10 + 8'(head);
        strobe();
        check("R4 chain redirect", {31'b0, redirect}, 1);
        check("R4 chain target", target, hnd(q[head]));
        check("R5 chain link", link_data, 32'h0000_0200);
        check("R7 chain ack id", {28'b0, ack_id}, {28'b0, q[head]});
        check("R2 chain gie", {31'b0, gie}, 1);
        if (ack && ack_id == q[head]) head++;
        else head = 3;
      end
      last_link = link_data;
      w_valid = 0;
      strobe();
      check("R6 final no redirect", {31'b0, redirect}, 0);
      check("R6 final no link write", {31'b0, link_we}, 0);
      check("R6 final no ack", {31'b0, ack}, 0);
      check("R6 link data unchanged", link_data, last_link);
      check("R2 final gie", {31'b0, gie}, 1);
    end
    summary();
  end
endmodule